// File: doc/BRIEF.md
# Reset-Counting Game Bank Selector

This block lets a multi-game cartridge step to the next game each time the console reset button is pressed. It watches the lowest CPU address line. While the CPU runs, that line changes state all the time. When the console holds the CPU in reset, the line goes quiet. A long enough quiet spell is taken as a reset, and the start of each reset moves a small game selector on by one step.

The selector has two parts: a source flag (original mask ROM or flash) and a flash partition number. The partition number drives the upper address bits of the flash, which splits the flash into equal partitions, one game per partition. The source flag decides which memory sees the CPU's chip-select request. Whichever memory is not selected has its select held inactive.

After power-on the original game runs. Successive resets walk through every flash partition in turn and then return to the original game. Only the power-on reset clears the selector.

Top module: `game_bank_selector`

## Requirements
- R1: During and right after power-on reset (`rst_n` low), the original game is selected, `flash_addr_hi` is 0 and `reset_seen` is 1.
- R2: `reset_seen` rises only after `cpu_a0` has stayed at one level for at least `GAP_CYCLES` clocks. It rises no later than `GAP_CYCLES`+8 clocks after the last change of `cpu_a0`.
- R3: `reset_seen` returns to 0 within 5 clocks of any change on `cpu_a0`.
- R4: Each rising edge of `reset_seen` advances the selector one step in this order: original, flash partition 0, 1, ..., 2^`BANK_BITS`-1, then back to original. `flash_addr_hi` carries the partition number as a plain binary value.
- R5: The end of a console reset (activity resuming on `cpu_a0`) leaves the selection unchanged. A quiet spell that lasts many times `GAP_CYCLES` advances it only once.
- R6: After power-on reset, if `cpu_a0` sits at either constant level with no change, the selection never advances.
- R7: While the original game is selected, `flash_ce_n` is 1, `flash_addr_hi` is 0, and `orig_ce_n` follows `rom_req_n`.
- R8: While a flash partition is selected, `orig_ce_n` is 1 and `flash_ce_n` follows `rom_req_n`. The two chip selects are never both 0.
- R9: Asserting `rst_n` at any point returns the selector to the original game.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| cpu_a0 | input | 1 | CPU address bit 0, asynchronous to `clk` |
| rom_req_n | input | 1 | CPU ROM chip-select request, active low |
| flash_addr_hi | output | BANK_BITS | Upper flash address bits (partition number) |
| flash_ce_n | output | 1 | Flash chip select, active low |
| orig_ce_n | output | 1 | Original mask ROM chip select, active low |
| reset_seen | output | 1 | Console reset detected (A0 quiet) |

## Verification
Two situations are hard to reach from the ports. The first is a static `cpu_a0` right after power-on, at either level: the synchronizer must not read the first sampled value as a transition, because that would start a false quiet spell and a spurious step. The bench releases reset with A0 held high and with A0 held low, and waits several gap lengths each time. The second is a console reset held far longer than the gap: the bench holds A0 quiet for many windows and checks that the selector moved once. Random activity bursts between gaps, random chip-select requests and repeated wraps of the selector cover the rest.

// File: rtl/game_sel_pkg.sv
// Shared types for the reset-counting game bank selector.
package game_sel_pkg;
    // Which memory currently owns the CPU chip-select request.
    typedef enum logic {
        SRC_ORIG  = 1'b0,
        SRC_FLASH = 1'b1
    } rom_src_e;
endpackage

// File: rtl/a0_edge_sync.sv
// Brings the asynchronous CPU A0 line into the clk domain through two flops
// and flags each transition. Assumes A0 may hold any level at reset release:
// transitions are masked until the delay line holds three valid samples, so
// the first sampled level is never taken as a change.
module a0_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic a0_i,
    output logic edge_o
);
    localparam int unsigned PRIME_DEPTH = 3;

    logic s1_q, s2_q, prev_q;
    logic [PRIME_DEPTH-1:0] prime_q;

    // Two-flop synchronizer plus one delay stage for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= a0_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Marks when every stage holds a real sample of A0.
    always_ff @(posedge clk) begin
        if (!rst_n) prime_q <= '0;
        else        prime_q <= {prime_q[PRIME_DEPTH-2:0], 1'b1};
    end

    // A transition is reported only once the delay line is primed.
    always_comb edge_o = prime_q[PRIME_DEPTH-1] && (s2_q != prev_q);
endmodule

// File: rtl/quiet_detector.sv
// Measures how long A0 has gone without a transition. Raises idle_o once the
// quiet spell reaches GAP_CYCLES and drops it on the next transition.
// Assumes power-on looks like a reset already in progress, so idle_o starts
// high; a rising edge then needs real activity followed by a new gap.
module quiet_detector #(
    parameter int unsigned GAP_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic idle_o
);
    localparam int unsigned CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GAP_CYCLES);

    logic [CW-1:0] quiet_q;
    logic          idle_q;

    // Counts quiet cycles, saturating at the limit. Sets idle at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= LIMIT;
            idle_q  <= 1'b1;
        end else if (edge_i) begin
            quiet_q <= '0;
            idle_q  <= 1'b0;
        end else if (quiet_q != LIMIT) begin
            quiet_q <= quiet_q + 1'b1;
            if (quiet_q == LIMIT - 1'b1) idle_q <= 1'b1;
        end
    end

    always_comb idle_o = idle_q;

    // A transition must clear the reset indication on the next cycle.
    assert_idle_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> !idle_o);

    // Idle never rises in the cycle right after a transition.
    assert_no_early_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> !$past(edge_i));
endmodule

// File: rtl/bank_stepper.sv
// Holds the game selection and steps it on each rising edge of the quiet
// indication. Order: original, flash partitions 0..N-1, then original again.
// Only rst_n clears it; falling idle (end of console reset) changes nothing.
module bank_stepper
    import game_sel_pkg::*;
#(
    parameter int unsigned BANK_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle_i,
    output rom_src_e             src_o,
    output logic [BANK_BITS-1:0] bank_o
);
    localparam logic [BANK_BITS-1:0] LAST_BANK = '1;

    logic                 idle_d_q;
    logic                 step;
    rom_src_e             src_q;
    logic [BANK_BITS-1:0] bank_q;

    // Delayed copy of idle for rising-edge detection. Starts high like idle.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_d_q <= 1'b1;
        else        idle_d_q <= idle_i;
    end

    always_comb step = idle_i && !idle_d_q;

    // Advances the selection by one position per detected reset start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_ORIG;
            bank_q <= '0;
        end else if (step) begin
            if (src_q == SRC_ORIG) begin
                src_q  <= SRC_FLASH;
                bank_q <= '0;
            end else if (bank_q == LAST_BANK) begin
                src_q  <= SRC_ORIG;
                bank_q <= '0;
            end else begin
                bank_q <= bank_q + 1'b1;
            end
        end
    end

    always_comb begin
        src_o  = src_q;
        bank_o = bank_q;
    end

    // A reset start always moves the selection.
    assert_step_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !idle_d_q) |=> ({src_o, bank_o} != $past({src_o, bank_o})));

    // Without a reset start the selection holds, including at reset release.
    assert_hold_otherwise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_i && !idle_d_q) |=> $stable({src_o, bank_o}));
endmodule

// File: rtl/game_bank_selector.sv
// Top of the reset-counting game selector. Detects console resets as a long
// quiet spell on CPU A0 and steps through the original game and each flash
// partition. Routes the CPU ROM request to exactly one memory.
module game_bank_selector
    import game_sel_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 50000,
    parameter int unsigned BANK_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_a0,
    input  logic                 rom_req_n,
    output logic [BANK_BITS-1:0] flash_addr_hi,
    output logic                 flash_ce_n,
    output logic                 orig_ce_n,
    output logic                 reset_seen
);
    logic                 a0_edge;
    logic                 idle;
    rom_src_e             src;
    logic [BANK_BITS-1:0] bank;

    a0_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .a0_i   (cpu_a0),
        .edge_o (a0_edge)
    );

    quiet_detector #(.GAP_CYCLES(GAP_CYCLES)) u_quiet (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (a0_edge),
        .idle_o (idle)
    );

    bank_stepper #(.BANK_BITS(BANK_BITS)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_i (idle),
        .src_o  (src),
        .bank_o (bank)
    );

    // Steers the request to the selected memory; the other stays deselected.
    always_comb begin
        flash_addr_hi = bank;
        flash_ce_n    = (src == SRC_FLASH) ? rom_req_n : 1'b1;
        orig_ce_n     = (src == SRC_ORIG)  ? rom_req_n : 1'b1;
        reset_seen    = idle;
    end

    // The two memories are never selected together.
    assert_ce_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_ce_n && !orig_ce_n));

    // While the original game runs the flash high bits rest at zero.
    assert_orig_bank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !orig_ce_n |-> (flash_addr_hi == '0));
endmodule

// File: tb/sim_game_bank_selector.sv
`timescale 1ns/1ps
module sim_game_bank_selector;
    localparam int unsigned GAP = 64;
    localparam int unsigned BB  = 2;
    localparam int unsigned NPART = 1 << BB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_a0 = 1'b0;
    logic          rom_req_n = 1'b1;
    logic [BB-1:0] flash_addr_hi;
    logic          flash_ce_n, orig_ce_n, reset_seen;

    int unsigned checks = 0;
    int unsigned fails  = 0;

    // Bench model of the selection: flash flag and partition number.
    logic          exp_flash = 1'b0;
    int unsigned   exp_bank  = 0;

    always #2.5 clk = ~clk;

    game_bank_selector #(.GAP_CYCLES(GAP), .BANK_BITS(BB)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_a0(cpu_a0), .rom_req_n(rom_req_n),
        .flash_addr_hi(flash_addr_hi), .flash_ce_n(flash_ce_n),
        .orig_ce_n(orig_ce_n), .reset_seen(reset_seen)
    );

    task automatic chk(string req, string what, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(int unsigned n);
        for (int unsigned i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected next selection per R4.
    task automatic model_step();
        if (!exp_flash) begin
            exp_flash = 1'b1;
            exp_bank  = 0;
        end else if (exp_bank == NPART - 1) begin
            exp_flash = 1'b0;
            exp_bank  = 0;
        end else begin
            exp_bank++;
        end
    endtask

    // Checks bank and chip selects against the model with a random request.
    task automatic chk_sel(string req);
        rom_req_n = 1'($urandom_range(0, 1));
        #1;
        chk(req, "flash_addr_hi", flash_addr_hi, exp_flash ? exp_bank : 0);
        chk(exp_flash ? "R8" : "R7", "flash_ce_n", flash_ce_n,
            exp_flash ? rom_req_n : 1);
        chk(exp_flash ? "R8" : "R7", "orig_ce_n", orig_ce_n,
            exp_flash ? 1 : rom_req_n);
    endtask

    task automatic power_on(logic lvl);
        @(negedge clk);
        rst_n  = 1'b0;
        cpu_a0 = lvl;
        cycles(4);
        // R1: state while reset is held
        chk("R1", "reset_seen in reset", reset_seen, 1);
        exp_flash = 1'b0;
        exp_bank  = 0;
        chk_sel("R1");
        rst_n = 1'b1;
        cycles(1);
        chk("R1", "reset_seen after release", reset_seen, 1);
    endtask

    // CPU running: random A0 pattern, first cycle forced to toggle.
    task automatic activity(int unsigned n);
        @(negedge clk);
        cpu_a0 = ~cpu_a0;
        for (int unsigned i = 1; i < n; i++) begin
            @(negedge clk);
            cpu_a0 = ($urandom_range(0, 3) == 0) ? cpu_a0 : ~cpu_a0;
        end
        @(negedge clk);
        cpu_a0 = ~cpu_a0;  // last change happens here
    endtask

    // A full console reset: activity, then a quiet spell that must step.
    task automatic console_reset(int unsigned hold_extra);
        activity($urandom_range(6, 40));
        // R3: activity has cleared the reset indication
        chk("R3", "reset_seen during activity", reset_seen, 0);
        cycles(GAP - 2);
        chk("R2", "reset_seen before gap", reset_seen, 0);
        cycles(10);
        chk("R2", "reset_seen after gap", reset_seen, 1);
        cycles(2);
        model_step();
        chk_sel("R4");
        cycles(hold_extra);
        chk_sel("R5");
        // Release: activity resumes, selection must not move
        @(negedge clk);
        cpu_a0 = ~cpu_a0;
        cycles(5);
        chk("R3", "reset_seen after A0 change", reset_seen, 0);
        chk_sel("R5");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R6: static high A0 after power-on never advances
        power_on(1'b1);
        cycles(3 * GAP);
        chk("R6", "reset_seen static high", reset_seen, 1);
        chk_sel("R6");
        // R6: static low A0 as well
        power_on(1'b0);
        cycles(3 * GAP);
        chk_sel("R6");

        // R4: two full rounds through all partitions and back to original
        for (int k = 0; k < 2 * (NPART + 1); k++)
            console_reset($urandom_range(0, 20));

        // R5: a very long quiet spell steps only once
        console_reset(5 * GAP);

        // R9: power-on reset mid-game returns to original
        console_reset(3);
        chk("R9", "flash selected before reset", exp_flash, 1);
        @(negedge clk);
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        exp_flash = 1'b0;
        exp_bank  = 0;
        cycles(1);
        chk_sel("R9");
        chk("R9", "reset_seen after reset", reset_seen, 1);

        // R8: request released, nothing selected
        console_reset(2);
        rom_req_n = 1'b1;
        #1;
        chk("R8", "flash_ce_n idle request", flash_ce_n, 1);
        chk("R8", "orig_ce_n idle request", orig_ce_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule